// File: doc/BRIEF.md
# Two-Wire Memory Client Protocol Engine

This block is the protocol core of a two-wire bus client that fronts a 1024-byte memory. Line conditioning lives outside it. The block receives single-cycle events: a start condition, a stop condition, a clock rising edge and a clock falling edge. It also receives the sampled data line. It drives one output that pulls the data line low (open drain). The engine decodes the control byte and the word address, keeps the address pointer, and serves current-address, random and sequential reads from a combinational memory read port.

Received write data goes out to a separate page write unit as one strobe per byte, with the address and the data. A commit pulse follows when the stop arrives. A busy input from that unit silences every acknowledge while its write cycle runs, so a host can poll for completion with control bytes.

Top module: `i2c_mem_client`

## Requirements
- R1: A control byte whose bits 7:4 equal 1010 is acknowledged, whatever the value of bit 3. Bit 0 selects the operation: 1 means read and 0 means write.
- R2: A control byte with any other code in bits 7:4 gets no acknowledge. The engine then ignores every later byte until the next start.
- R3: While the busy input is high, no byte is acknowledged, including a valid control byte.
- R4: For a write, control bits 2:1 become address bits 9:8 and the word address byte becomes bits 7:0. Each data byte issues one write strobe that carries this address and the byte.
- R5: Within one write transfer, each data byte advances only the lowest 4 address bits, so the address wraps inside a 16-byte page.
- R6: A stop that follows at least one data byte issues one commit pulse. A repeated start, or a stop with no data byte before it, issues none.
- R7: A read with no address phase returns the byte at the last accessed address plus one. This holds whether the previous access was a read or a write. Block bits in a read control byte are ignored.
- R8: A write control byte, a word address, a repeated start and a read control byte together return the byte at the address that was just set.
- R9: During a read, a host acknowledge sends the next byte. The pointer wraps from 3FFh to 000h.
- R10: After the host withholds its acknowledge, the engine keeps the line released until the next start.
- R11: The acknowledge holds the line low from the clock fall after the 8th bit to the clock fall after the 9th bit. Read data is driven most significant bit first, and each bit changes on a clock fall.
- R12: A start or a stop in any state releases the line at once. A start returns the engine to receiving a control byte, and a stop returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start (or repeated start) detected |
| ev_stop | input | 1 | Stop detected |
| scl_rise | input | 1 | Bus clock rising edge |
| scl_fall | input | 1 | Bus clock falling edge |
| sda_in | input | 1 | Sampled data line |
| wr_busy | input | 1 | Write cycle in progress |
| rd_data | input | 8 | Memory byte at rd_addr |
| sda_oe | output | 1 | Pull data line low |
| rd_addr | output | 10 | Memory read address (pointer) |
| wr_strobe | output | 1 | One received write byte |
| wr_addr | output | 10 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Stop after write data: start the write cycle |

## Verification
The hardest case to reach is an abort that lands in the middle of a frame. One example is a start that arrives while the engine is driving a zero data bit. Another is a stop that arrives while the acknowledge is still held. Neither occurs in a well-formed transfer. The bench first searches the memory contents it models for an address whose byte has its top bit clear, so that the first driven bit really pulls the line low. It points a random read at that address and cuts the transfer off at that point. It then checks that the line is released and that the pointer has not moved.

// File: rtl/i2c_mem_client.sv
module i2c_mem_client #(
  parameter int AW = 10,
  parameter int PW = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          wr_busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  localparam int BW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_WADDR, S_WDATA, S_RDATA} st_t;

  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, osh;
  logic [AW-1:0] ptr;
  logic [BW-1:0] blk;
  logic          rw, ackd, hack, wrote;
  logic          ack_ok;

  assign rd_addr = ptr;
  assign ack_ok  = !wr_busy && (st != S_CTRL || sh[7:4] == DEV_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; osh <= '0; ptr <= '0; blk <= '0;
      rw <= 1'b0; ackd <= 1'b0; hack <= 1'b0; wrote <= 1'b0; sda_oe <= 1'b0;
      wr_strobe <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      wr_commit <= 1'b0;
      if (ev_start) begin
        st <= S_CTRL; cnt <= '0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (ev_stop) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
        wr_commit <= wrote; wrote <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            if (st != S_RDATA) sh <= {sh[6:0], sda_in};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            hack <= !sda_in;
          end
        end else if (scl_fall) begin
          if (st == S_RDATA) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sda_oe <= !osh[6];
              osh <= {osh[6:0], 1'b0};
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr <= ptr + 1'b1;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (hack) begin
                osh <= rd_data;
                sda_oe <= !rd_data[7];
              end else begin
                sda_oe <= 1'b0;
                st <= S_IDLE;
              end
            end
          end else if (cnt == 4'd8) begin
            sda_oe <= ack_ok;
            ackd <= ack_ok;
            if (ack_ok) begin
              case (st)
                S_CTRL: begin blk <= sh[BW:1]; rw <= sh[0]; end
                S_WADDR: ptr <= {blk, sh};
                S_WDATA: begin
                  wr_strobe <= 1'b1; wr_addr <= ptr; wr_data <= sh; wrote <= 1'b1;
                  ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
                end
                default: ;
              endcase
            end
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_oe <= 1'b0;
            if (!ackd) st <= S_IDLE;
            else if (st == S_CTRL && rw) begin
              st <= S_RDATA;
              osh <= rd_data;
              sda_oe <= !rd_data[7];
            end else if (st == S_CTRL) st <= S_WADDR;
            else st <= S_WDATA;
          end
        end
      end
    end
  end
endmodule

module i2c_mem_client_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_start,
  input logic ev_stop,
  input logic scl_fall,
  input logic wr_busy,
  input logic sda_oe,
  input logic wr_strobe,
  input logic wr_commit
);
  a_r3_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !$rose(sda_oe));
  a_r12_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);
  a_r12_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
  a_r11_line_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || ev_start || ev_stop));
  a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop));
  a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(scl_fall));
endmodule

bind i2c_mem_client i2c_mem_client_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .scl_fall(scl_fall), .wr_busy(wr_busy), .sda_oe(sda_oe),
  .wr_strobe(wr_strobe), .wr_commit(wr_commit)
);

// File: tb/sim_i2c_mem_client.sv
module sim_i2c_mem_client;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, scl_rise = 0, scl_fall = 0, sda_in = 1, wr_busy = 0;
  logic [7:0] rd_data, wr_data;
  logic [9:0] rd_addr, wr_addr;
  logic sda_oe, wr_strobe, wr_commit;

  int nchk = 0, nfail = 0, ns = 0, ncommit = 0;
  logic [9:0] sa [16];
  logic [7:0] sd [16];
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mdata(logic [9:0] a);
    return 8'((int'(a) * 37) ^ (int'(a) >> 2));
  endfunction
  assign rd_data = mdata(rd_addr);

  i2c_mem_client u0 (.clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .wr_busy(wr_busy),
    .rd_data(rd_data), .sda_oe(sda_oe), .rd_addr(rd_addr), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  always @(negedge clk) begin
    if (wr_strobe && ns < 16) begin sa[ns] = wr_addr; sd[ns] = wr_data; ns++; end
    if (wr_commit) ncommit++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic start_c(); ev_start = 1; tick(1); ev_start = 0; tick(2); endtask
  task automatic stop_c();  ev_stop = 1;  tick(1); ev_stop = 0;  tick(2); endtask

  task automatic clk_bit(input logic b, output logic line);
    sda_in = b; tick(2);
    scl_rise = 1; tick(1); scl_rise = 0; tick(2);
    line = sda_in & ~sda_oe;
    scl_fall = 1; tick(1); scl_fall = 0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic line;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], line);
    clk_bit(1'b1, line);
    ack = !line;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic line;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, line); d[i] = line; end
    clk_bit(!host_ack, line);
  endtask

  task automatic set_ptr(input logic [9:0] a);
    logic ack;
    start_c();
    send_byte({4'hA, 1'b0, a[9:8], 1'b0}, ack); chk("R8 addr ctrl ack", ack, 1);
    send_byte(a[7:0], ack);                     chk("R8 word ack", ack, 1);
    start_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack, line;
    logic [7:0] d;
    logic [9:0] a;
    int c0;
    tick(3);
    chk("R12 reset line released", sda_oe, 0);
    chk("R4 reset no strobe", wr_strobe, 0);
    rst_n = 1; tick(2);

    // R1 / R2: sweep all code nibbles with a write control byte
    for (int c = 0; c < 16; c++) begin
      start_c();
      send_byte({4'(c), 4'b0000}, ack);
      chk(c == 10 ? "R1 code match ack" : "R2 code mismatch no ack", ack, c == 10);
      if (c != 10) begin
        send_byte(8'hA0, ack);
        chk("R2 ignored until start", ack, 0);
      end
      chk("R11 released after ack clock", sda_oe, 0);
      stop_c();
    end
    chk("R6 no commit without data", ncommit, 0);

    // R4 / R5 / R6: page write, bit3 set, block 2, crossing the page end
    start_c();
    send_byte(8'hAC, ack); chk("R1 bit3 ignored", ack, 1);
    send_byte(8'h3E, ack); chk("R4 word ack", ack, 1);
    send_byte(8'h11, ack); chk("R4 data ack", ack, 1);
    send_byte(8'h22, ack); chk("R4 data ack", ack, 1);
    send_byte(8'h33, ack); chk("R4 data ack", ack, 1);
    stop_c();
    chk("R4 strobe count", ns, 3);
    chk("R4 addr0", sa[0], 10'h23E); chk("R4 data0", sd[0], 8'h11);
    chk("R5 addr1", sa[1], 10'h23F); chk("R4 data1", sd[1], 8'h22);
    chk("R5 page wrap addr2", sa[2], 10'h230); chk("R4 data2", sd[2], 8'h33);
    chk("R6 commit after data", ncommit, 1);

    // R7: current address reads after write and after read
    start_c();
    send_byte(8'hA7, ack); chk("R1 read ctrl ack", ack, 1);
    recv_byte(1'b0, d);    chk("R7 after write", d, mdata(10'h231));
    stop_c();
    start_c();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);    chk("R7 after read", d, mdata(10'h232));
    stop_c();

    // R3: busy silences everything
    wr_busy = 1;
    start_c();
    send_byte(8'hA0, ack); chk("R3 busy write ctrl", ack, 0);
    stop_c();
    start_c();
    send_byte(8'hA1, ack); chk("R3 busy read ctrl", ack, 0);
    stop_c();
    wr_busy = 0;

    // R8: random reads over every block
    for (int b = 0; b < 4; b++) begin
      a = {2'(b), 8'h80 + 8'(b)};
      set_ptr(a);
      send_byte(8'hA1, ack); chk("R8 read ctrl ack", ack, 1);
      recv_byte(1'b1, d);    chk("R8 random byte", d, mdata(a));
      recv_byte(1'b0, d);    chk("R9 next byte", d, mdata(a + 10'd1));
      stop_c();
    end
    chk("R6 repeated start no commit", ncommit, 1);

    // R9 / R10: sequential read across the top of the array
    set_ptr(10'h3FE);
    send_byte(8'hA1, ack);
    recv_byte(1'b1, d); chk("R9 3FE", d, mdata(10'h3FE));
    recv_byte(1'b1, d); chk("R9 3FF", d, mdata(10'h3FF));
    recv_byte(1'b1, d); chk("R9 wrap 000", d, mdata(10'h000));
    recv_byte(1'b0, d); chk("R9 001", d, mdata(10'h001));
    for (int i = 0; i < 9; i++) clk_bit(1'b1, line);
    chk("R10 released after nack", sda_oe, 0);
    chk("R10 line high after nack", line, 1);
    stop_c();
    start_c();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d); chk("R7 after wrap", d, mdata(10'h002));
    stop_c();

    // R12: start while a zero data bit is driven
    c0 = 0;
    for (int i = 0; i < 64; i++) if (c0 == 0 && mdata(10'h100 + 10'(i))[7] == 1'b0) c0 = 256 + i;
    a = 10'(c0);
    set_ptr(a);
    send_byte(8'hA1, ack);
    chk("R11 msb driven first", sda_oe, 1);
    start_c();
    chk("R12 start releases line", sda_oe, 0);
    send_byte(8'hA1, ack); chk("R12 back to control", ack, 1);
    recv_byte(1'b0, d);    chk("R12 pointer unmoved", d, mdata(a));
    stop_c();

    // R12: stop while the acknowledge is held
    start_c();
    for (int i = 7; i >= 0; i--) clk_bit(8'hA0 >> i, line);
    chk("R11 ack held after 8th bit", sda_oe, 1);
    stop_c();
    chk("R12 stop releases line", sda_oe, 0);
    send_byte(8'hA0, ack); chk("R12 idle after stop", ack, 0);
    chk("R6 no commit on aborted write", ncommit, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule